// File: doc/BRIEF.md
# Float register rename map

This block holds the mapping from architectural floating-point register numbers to physical register indices in an out-of-order core. When a destination register is renamed, the block takes the physical index the float free list is currently offering, writes it into the entry for that architectural register, and returns the new mapping together with the one it replaced. The replaced index goes to commit logic, which frees it once the renaming instruction retires. A separate lookup port translates source operands.

One architectural float register can be set up as a hardwired zero. With that option on, renaming it takes nothing from the free list and always yields a fixed physical index. With the option off, that register is renamed like any other. Physical float indices sit above the integer ones. Any index the free list hands over that falls outside the float range is flagged as an error.

Top module: `fpr_rename_map`

## Requirements
- R1: After reset, a lookup of architectural register i returns physical index NUM_INT_PHYS + i, and `ren_done` is low.
- R2: A rename request (`ren_valid` high) for a non-zero register while `fl_avail` is high raises `ren_ready` and `fl_pop` in the same cycle. One cycle later, `ren_done` is high, `ren_new_phys` equals the `fl_phys` value that was offered, and `ren_old_phys` equals the mapping the register had before.
- R3: A lookup presents `lk_arch` and gets `lk_phys` one cycle later. After a rename has completed, a lookup of that register returns the newly allocated index.
- R4: A rename request for a non-zero register while `fl_avail` is low drops `ren_ready` and `fl_pop`, produces no `ren_done`, and leaves the mapping unchanged.
- R5: With ZERO_EN = 1, a rename of register ZERO_ARCH is accepted whether or not `fl_avail` is high. It never asserts `fl_pop`, it returns NUM_INT_PHYS + ZERO_ARCH on both `ren_new_phys` and `ren_old_phys`, and it leaves the mapping unchanged.
- R6: With ZERO_EN = 0, register ZERO_ARCH is renamed exactly as in R2, including the pop and the map update.
- R7: `range_err` goes high together with `ren_done` when the allocated index is below NUM_INT_PHYS or at or above NUM_PHYS. The mapping is still written in that case.
- R8: When a lookup and a rename target the same register in the same cycle, the lookup returns the mapping from before the rename.
- R9: For two renames of the same register in a row, the second one returns the first one's new index as its `ren_old_phys`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request |
| ren_arch | input | $clog2(NUM_ARCH) | Architectural destination register |
| ren_ready | output | 1 | Request accepted this cycle |
| fl_avail | input | 1 | Free list has an entry to offer |
| fl_phys | input | $clog2(NUM_PHYS) | Physical index offered by the free list |
| fl_pop | output | 1 | Consume the offered free-list entry |
| ren_done | output | 1 | Rename result valid (registered) |
| ren_new_phys | output | $clog2(NUM_PHYS) | New physical mapping |
| ren_old_phys | output | $clog2(NUM_PHYS) | Replaced physical mapping |
| range_err | output | 1 | Allocated index outside the float range |
| lk_arch | input | $clog2(NUM_ARCH) | Source register to translate |
| lk_phys | output | $clog2(NUM_PHYS) | Translated index (one-cycle latency) |

## Verification
The hardest case to reach is a rename and a lookup of the same register landing in the same cycle, because the outcome depends on whether the map is read before or after it is written. The bench drives both ports to one register on the same edge and checks `lk_phys` on two consecutive cycles: first the old mapping, then the new one. A second instance, built with the zero option off, shows that register ZERO_ARCH pops the free list there while the first instance leaves it untouched. Renames that offer out-of-range indices from below and from above the float range exercise the error flag at both of its boundaries.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [1:0] {
    REN_IDLE  = 2'd0,
    REN_ALLOC = 2'd1,
    REN_ZERO  = 2'd2,
    REN_STALL = 2'd3
  } ren_kind_e;
endpackage

// File: rtl/fpr_range_check.sv
module fpr_range_check #(
  parameter int LO = 64,
  parameter int HI = 96,
  parameter int PW = 7
) (
  input  logic [PW-1:0] idx,
  output logic          ok
);
  always_comb ok = (int'(idx) >= LO) && (int'(idx) < HI);
endmodule

// File: rtl/fpr_map_table.sv
module fpr_map_table #(
  parameter int DEPTH = 32,
  parameter int BASE  = 64,
  parameter int AW    = 5,
  parameter int PW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [PW-1:0] wr_data,
  input  logic [AW-1:0] ra_addr,
  output logic [PW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [PW-1:0] rb_data
);
  logic [PW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= PW'(BASE + i);
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // Rename read port: combinational, so the old mapping is read before the write.
  always_comb ra_data = mem[ra_addr];

  // Lookup read port: registered, and it sees the value from before a same-edge write.
  always_ff @(posedge clk) begin
    if (rst) rb_data <= '0;
    else     rb_data <= mem[rb_addr];
  end

  AST_MAP_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data)); // R3
endmodule

// File: rtl/fpr_rename_map.sv
module fpr_rename_map #(
  parameter int NUM_ARCH     = 32,
  parameter int NUM_INT_PHYS = 64,
  parameter int NUM_PHYS     = 96,
  parameter bit ZERO_EN      = 1'b1,
  parameter int ZERO_ARCH    = 31,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ren_valid,
  input  logic [AW-1:0] ren_arch,
  output logic          ren_ready,
  input  logic          fl_avail,
  input  logic [PW-1:0] fl_phys,
  output logic          fl_pop,
  output logic          ren_done,
  output logic [PW-1:0] ren_new_phys,
  output logic [PW-1:0] ren_old_phys,
  output logic          range_err,
  input  logic [AW-1:0] lk_arch,
  output logic [PW-1:0] lk_phys
);
  import fpr_pkg::*;

  localparam logic [PW-1:0] ZERO_PHYS = PW'(NUM_INT_PHYS + ZERO_ARCH);

  logic          is_zero;
  ren_kind_e     kind;
  logic [PW-1:0] cur_map;
  logic          idx_ok;

  always_comb is_zero = ZERO_EN && (ren_arch == AW'(ZERO_ARCH));

  always_comb begin
    if (!ren_valid)    kind = REN_IDLE;
    else if (is_zero)  kind = REN_ZERO;
    else if (fl_avail) kind = REN_ALLOC;
    else               kind = REN_STALL;
  end

  always_comb begin
    ren_ready = is_zero || fl_avail;
    fl_pop    = (kind == REN_ALLOC);
  end

  fpr_map_table #(
    .DEPTH(NUM_ARCH), .BASE(NUM_INT_PHYS), .AW(AW), .PW(PW)
  ) u_table (
    .clk(clk), .rst(rst),
    .wr_en(fl_pop), .wr_addr(ren_arch), .wr_data(fl_phys),
    .ra_addr(ren_arch), .ra_data(cur_map),
    .rb_addr(lk_arch), .rb_data(lk_phys)
  );

  fpr_range_check #(
    .LO(NUM_INT_PHYS), .HI(NUM_PHYS), .PW(PW)
  ) u_range (
    .idx(fl_phys), .ok(idx_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ren_done     <= 1'b0;
      ren_new_phys <= '0;
      ren_old_phys <= '0;
      range_err    <= 1'b0;
    end else begin
      ren_done  <= (kind == REN_ALLOC) || (kind == REN_ZERO);
      range_err <= (kind == REN_ALLOC) && !idx_ok;
      if (kind == REN_ZERO) begin
        ren_new_phys <= ZERO_PHYS;
        ren_old_phys <= ZERO_PHYS;
      end else if (kind == REN_ALLOC) begin
        ren_new_phys <= fl_phys;
        ren_old_phys <= cur_map;
      end
    end
  end

  AST_POP_HAS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    fl_pop |-> fl_avail && ren_valid); // R2
  AST_NO_DONE_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && !ren_ready) |=> !ren_done); // R4
  AST_ZERO_NO_POP: assert property (@(posedge clk) disable iff (rst)
    (ZERO_EN && ren_valid && ren_arch == AW'(ZERO_ARCH)) |-> !fl_pop); // R5
  AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (rst)
    (ZERO_EN && ren_valid && ren_arch == AW'(ZERO_ARCH)) |=>
      (ren_done && ren_new_phys == ZERO_PHYS && ren_old_phys == ZERO_PHYS)); // R5
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    range_err |-> ren_done); // R7
  AST_NEW_FROM_LIST: assert property (@(posedge clk) disable iff (rst)
    fl_pop |=> (ren_new_phys == $past(fl_phys))); // R2
endmodule

// File: tb/test_fpr_rename_map.sv
module test_fpr_rename_map;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       a_valid = 0, a_ready, a_avail = 0, a_pop, a_done, a_err;
  logic [4:0] a_arch = '0, a_lk = '0;
  logic [6:0] a_fl = '0, a_new, a_old, a_lkp;

  logic       b_valid = 0, b_ready, b_avail = 0, b_pop, b_done, b_err;
  logic [4:0] b_arch = '0, b_lk = '0;
  logic [6:0] b_fl = '0, b_new, b_old, b_lkp;

  fpr_rename_map i_fpr_rename_map (
    .clk(clk), .rst(rst), .ren_valid(a_valid), .ren_arch(a_arch), .ren_ready(a_ready),
    .fl_avail(a_avail), .fl_phys(a_fl), .fl_pop(a_pop), .ren_done(a_done),
    .ren_new_phys(a_new), .ren_old_phys(a_old), .range_err(a_err),
    .lk_arch(a_lk), .lk_phys(a_lkp));

  fpr_rename_map #(.ZERO_EN(1'b0)) i_fpr_rename_map_nz (
    .clk(clk), .rst(rst), .ren_valid(b_valid), .ren_arch(b_arch), .ren_ready(b_ready),
    .fl_avail(b_avail), .fl_phys(b_fl), .fl_pop(b_pop), .ren_done(b_done),
    .ren_new_phys(b_new), .ren_old_phys(b_old), .range_err(b_err),
    .lk_arch(b_lk), .lk_phys(b_lkp));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic lookup(input int arch, input int exp, input string req);
    @(negedge clk);
    a_lk = 5'(arch);
    @(negedge clk);
    chk(a_lkp == 7'(exp), req, a_lkp, exp);
  endtask

  task automatic rename(input int arch, input int phys, input bit avail,
                        input bit exp_rdy, input bit exp_pop, input bit exp_done,
                        input int exp_new, input int exp_old, input bit exp_err,
                        input string req);
    @(negedge clk);
    a_valid = 1; a_arch = 5'(arch); a_fl = 7'(phys); a_avail = avail;
    #1;
    chk(a_ready == exp_rdy, {req, " ready"}, a_ready, exp_rdy);
    chk(a_pop == exp_pop, {req, " pop"}, a_pop, exp_pop);
    @(negedge clk);
    a_valid = 0; a_avail = 0;
    chk(a_done == exp_done, {req, " done"}, a_done, exp_done);
    if (exp_done) begin
      chk(a_new == 7'(exp_new), {req, " new"}, a_new, exp_new);
      chk(a_old == 7'(exp_old), {req, " old"}, a_old, exp_old);
    end
    chk(a_err == exp_err, {req, " err"}, a_err, exp_err);
  endtask

  task automatic t_reset;
    chk(a_done == 0, "R1 done", a_done, 0);
    for (int i = 0; i < 32; i++) lookup(i, 64 + i, "R1 reset map");
  endtask

  task automatic t_alloc;
    rename(3, 70, 1, 1, 1, 1, 70, 67, 0, "R2");
    lookup(3, 70, "R3 after rename");
    rename(0, 90, 1, 1, 1, 1, 90, 64, 0, "R2 reg0");
    lookup(0, 90, "R3 reg0");
  endtask

  task automatic t_back2back;
    rename(5, 80, 1, 1, 1, 1, 80, 69, 0, "R9 first");
    rename(5, 81, 1, 1, 1, 1, 81, 80, 0, "R9 second");
  endtask

  task automatic t_stall;
    rename(7, 88, 0, 0, 0, 0, 0, 0, 0, "R4");
    lookup(7, 71, "R4 map unchanged");
  endtask

  task automatic t_zero;
    rename(31, 77, 0, 1, 0, 1, 95, 95, 0, "R5 no entry");
    rename(31, 77, 1, 1, 0, 1, 95, 95, 0, "R5 entry offered");
    lookup(31, 95, "R5 map unchanged");
  endtask

  task automatic t_nozero;
    @(negedge clk);
    b_valid = 1; b_arch = 5'd31; b_fl = 7'd66; b_avail = 1;
    #1;
    chk(b_pop == 1, "R6 pop", b_pop, 1);
    @(negedge clk);
    b_valid = 0; b_avail = 0;
    chk(b_done == 1, "R6 done", b_done, 1);
    chk(b_new == 7'd66, "R6 new", b_new, 66);
    chk(b_old == 7'd95, "R6 old", b_old, 95);
    b_lk = 5'd31;
    @(negedge clk);
    @(negedge clk);
    chk(b_lkp == 7'd66, "R6 lookup", b_lkp, 66);
  endtask

  task automatic t_range;
    rename(9, 10, 1, 1, 1, 1, 10, 73, 1, "R7 low");
    lookup(9, 10, "R7 written");
    rename(9, 100, 1, 1, 1, 1, 100, 10, 1, "R7 high");
    rename(9, 64, 1, 1, 1, 1, 64, 100, 0, "R7 lower edge");
    rename(9, 95, 1, 1, 1, 1, 95, 64, 0, "R7 upper edge");
  endtask

  task automatic t_same;
    @(negedge clk);
    a_valid = 1; a_arch = 5'd12; a_fl = 7'd88; a_avail = 1; a_lk = 5'd12;
    @(negedge clk);
    a_valid = 0; a_avail = 0;
    chk(a_lkp == 7'd76, "R8 pre-rename value", a_lkp, 76);
    @(negedge clk);
    chk(a_lkp == 7'd88, "R8 next cycle", a_lkp, 88);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_alloc;
    t_back2back;
    t_stall;
    t_zero;
    t_nozero;
    t_range;
    t_same;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule